// File: doc/BRIEF.md
# Multi-Latency Result Staging with Call Hold

This block is one shared execution pipeline. A fast unit (add) and a slow unit (multiply) sit behind the same two operand inputs. Each unit has a fixed, exposed latency, set by the parameters `LAT_FAST` (default 1) and `LAT_SLOW` (default 3). Each latency class owns one result register. In any cycle, the results that complete form one drop group. The group is packed into output lanes with the lower latency class first.

The block also keeps a call-depth counter. It is driven by a small frame state machine with the states `FR_TOP` (depth 0) and `FR_NESTED` (depth above 0). The transitions are:
- `FR_TOP`→`FR_NESTED` on a call.
- `FR_NESTED`→`FR_NESTED` on a deeper call, or on a return to a depth still above 0.
- `FR_NESTED`→`FR_TOP` on a return from depth 1.
- A return in `FR_TOP` and a call together with a return are self-loops that leave the depth unchanged.

Every in-flight result is tagged with the depth at which it was issued. While a different frame runs, the result's remaining count is frozen. It resumes when its own frame runs again, so a call appears atomic to the caller's pipeline. When a return leaves a frame, that frame's in-flight results are dropped for good.

Top module: `latency_drop_stager`

## Requirements
- R1: After reset, and on the first cycle after any reset, `drop_valid` is 0, `drop_count` is 0 and `drop_data` is 0, even if results were in flight when reset was applied.
- R2: Opcode 0 is the fast class. It yields `(src_a + src_b) mod 2^DATA_W`. If it is issued in cycle t and the frame does not change, the result drops in cycle t+1.
- R3: Opcode 1 is the slow class. It yields the low `DATA_W` bits of `src_a * src_b`. If it is issued in cycle t with no frame change, it drops in cycle t+3. One slow op may be issued every cycle.
- R4: When a fast and a slow result complete in the same cycle, both drop together. Lane 0 (`drop_data[DATA_W-1:0]`) carries the fast result, lane 1 carries the slow result, and `drop_count` is 2.
- R5: A lone drop always sits in lane 0, whatever its class. Lane 1 is then invalid with data 0, and `drop_count` is 1.
- R6: Each issued result needs L-1 cycles of its own frame before delivery, then drops in the next cycle that its own frame runs. Cycles spent in deeper frames do not count, and no result drops into a deeper frame.
- R7: An op issued in the same cycle as `call_req` belongs to the caller. It is held until the caller runs again.
- R8: Under nested calls, a result is released only when the depth returns to exactly its issue depth. The depth goes up by one per call and down by one per return.
- R9: On a return, every in-flight result tagged with a depth above the new depth is discarded and never drops. This includes an op issued in the same cycle as the return.
- R10: `ret_req` at depth 0 is ignored. `call_req` and `ret_req` together leave the depth unchanged. In both cases in-flight results keep counting and drop on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_op | input | 1 | 0 = fast add class, 1 = slow multiply class |
| src_a | input | DATA_W | First operand |
| src_b | input | DATA_W | Second operand |
| call_req | input | 1 | A call is entered this cycle (depth rises next cycle) |
| ret_req | input | 1 | A return happens this cycle (depth falls next cycle) |
| drop_valid | output | 2 | Valid bit per drop lane, lane 0 filled first |
| drop_data | output | 2*DATA_W | Packed lane results, lane 0 in the low bits |
| drop_count | output | 2 | Number of results dropping this cycle |

## Verification
The hardest situation to reach is a frozen result whose remaining count has to resume with no error. This happens when the call lands on the issue cycle itself or between issue and completion. It also happens when the frame is left and re-entered through nested calls, or when the frame dies by a return while results are still in flight. The stimulus sweeps the call offset from 0 to 3 cycles after a slow issue against call lengths of 1 to 3. It places fast ops inside the callee and issues ops on the same cycle as a return. A scoreboard works out each expected drop cycle by counting the cycles owned by the issuing frame, taken from the depth trace the bench itself drives.

// File: rtl/stager_pkg.sv
package stager_pkg;

    // Class index doubles as the opcode value
    localparam logic CLS_FAST = 1'b0;
    localparam logic CLS_SLOW = 1'b1;

    typedef enum logic {
        FR_TOP    = 1'b0,
        FR_NESTED = 1'b1
    } frame_state_e;

endpackage

// File: rtl/frame_tracker.sv
module frame_tracker
    import stager_pkg::*;
#(
    parameter int DEPTH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               call_req,
    input  logic               ret_req,
    output logic [DEPTH_W-1:0] cur_depth,
    output logic [DEPTH_W-1:0] nxt_depth
);

    localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};

    frame_state_e state_q, state_d;
    logic [DEPTH_W-1:0] depth_q;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_TOP;
            depth_q <= '0;
        end else begin
            state_q <= state_d;
            depth_q <= nxt_depth;
        end
    end

    // Next-state and output process
    always_comb begin
        state_d   = state_q;
        nxt_depth = depth_q;
        unique case (state_q)
            FR_TOP: begin
                if (call_req && !ret_req) begin
                    state_d   = FR_NESTED;
                    nxt_depth = depth_q + 1'b1;
                end
            end
            FR_NESTED: begin
                if (call_req && !ret_req && depth_q != DEPTH_MAX) begin
                    nxt_depth = depth_q + 1'b1;
                end else if (ret_req && !call_req) begin
                    nxt_depth = depth_q - 1'b1;
                    if (depth_q == DEPTH_W'(1)) state_d = FR_TOP;
                end
            end
            default: state_d = FR_TOP;
        endcase
    end

    assign cur_depth = depth_q;

    // R10
    property hold_depth_on_both;
        @(posedge clk) disable iff (!rst_n) (call_req && ret_req) |=> $stable(depth_q);
    endproperty
    both_reqs_noop_chk: assert property (hold_depth_on_both);

    // R8
    property single_step_return;
        @(posedge clk) disable iff (!rst_n)
            (state_q == FR_NESTED && ret_req && !call_req) |=> (depth_q == $past(depth_q) - 1'b1);
    endproperty
    return_step_chk: assert property (single_step_return);

    // R8
    property top_means_zero;
        @(posedge clk) disable iff (!rst_n) (state_q == FR_TOP) == (depth_q == '0);
    endproperty
    top_depth_chk: assert property (top_means_zero);

endmodule

// File: rtl/stage_lane.sv
module stage_lane #(
    parameter int DATA_W  = 8,
    parameter int DEPTH_W = 3,
    parameter int LAT     = 1,
    parameter int SLOTS   = 4,
    parameter bit IS_MUL  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iss,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    input  logic [DEPTH_W-1:0] cur_depth,
    input  logic [DEPTH_W-1:0] nxt_depth,
    output logic               drop_v,
    output logic [DATA_W-1:0]  drop_d
);

    localparam int CNT_W = $clog2(LAT) + 1;
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] REM_INIT = CNT_W'(LAT - 1);

    logic [SLOTS-1:0]   s_v;
    logic [CNT_W-1:0]   s_rem [SLOTS];
    logic [DEPTH_W-1:0] s_dep [SLOTS];
    logic [DATA_W-1:0]  s_dat [SLOTS];

    logic [CNT_W-1:0]   eff [SLOTS];
    logic [SLOTS-1:0]   fire, gone;
    logic [DATA_W-1:0]  fire_dat, result;
    logic [IDX_W-1:0]   free_idx;
    logic               free_ok, iss_fire, iss_gone;

    if (IS_MUL) begin : g_mul
        assign result = opa * opb;
    end else begin : g_add
        assign result = opa + opb;
    end

    always_comb begin
        fire_dat = '0;
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            eff[i]  = (s_v[i] && s_dep[i] == cur_depth && s_rem[i] != '0)
                      ? s_rem[i] - CNT_W'(1) : s_rem[i];
            fire[i] = s_v[i] && eff[i] == '0 && s_dep[i] == nxt_depth;
            gone[i] = s_v[i] && s_dep[i] > nxt_depth;
            if (fire[i]) fire_dat = fire_dat | s_dat[i];
            if (!s_v[i] && !free_ok) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        iss_fire = iss && (REM_INIT == '0) && (nxt_depth == cur_depth);
        iss_gone = iss && (cur_depth > nxt_depth);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_v    <= '0;
            drop_v <= 1'b0;
            drop_d <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                s_rem[i] <= '0;
                s_dep[i] <= '0;
                s_dat[i] <= '0;
            end
        end else begin
            drop_v <= iss_fire || (|fire);
            drop_d <= iss_fire ? result : fire_dat;
            for (int i = 0; i < SLOTS; i++) begin
                if (fire[i] || gone[i]) s_v[i] <= 1'b0;
                else                    s_rem[i] <= eff[i];
            end
            if (iss && !iss_fire && !iss_gone && free_ok) begin
                s_v[free_idx]   <= 1'b1;
                s_rem[free_idx] <= REM_INIT;
                s_dep[free_idx] <= cur_depth;
                s_dat[free_idx] <= result;
            end
        end
    end

    // R6
    property no_slot_collision;
        @(posedge clk) disable iff (!rst_n) $onehot0(fire) && !(iss_fire && (|fire));
    endproperty
    single_fire_chk: assert property (no_slot_collision);

    if (LAT == 1) begin : g_fast_chk
        // R2
        property fast_next_cycle;
            @(posedge clk) disable iff (!rst_n) (iss && nxt_depth == cur_depth) |=> drop_v;
        endproperty
        fast_lat_chk: assert property (fast_next_cycle);
    end

endmodule

// File: rtl/latency_drop_stager.sv
module latency_drop_stager
    import stager_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH_W  = 3,
    parameter int LAT_FAST = 1,
    parameter int LAT_SLOW = 3,
    parameter int SLOTS    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic                issue_op,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    input  logic                call_req,
    input  logic                ret_req,
    output logic [1:0]          drop_valid,
    output logic [2*DATA_W-1:0] drop_data,
    output logic [1:0]          drop_count
);

    localparam int NCLS = 2;

    logic [DEPTH_W-1:0] cur_depth, nxt_depth;
    logic [NCLS-1:0]    lv;
    logic [DATA_W-1:0]  ld [NCLS];

    frame_tracker #(.DEPTH_W(DEPTH_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_req  (call_req),
        .ret_req   (ret_req),
        .cur_depth (cur_depth),
        .nxt_depth (nxt_depth)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_lane
        localparam int L = (c == 0) ? LAT_FAST : LAT_SLOW;
        stage_lane #(
            .DATA_W  (DATA_W),
            .DEPTH_W (DEPTH_W),
            .LAT     (L),
            .SLOTS   (SLOTS),
            .IS_MUL  (c != 0)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .iss       (issue_valid && (issue_op == 1'(c))),
            .opa       (src_a),
            .opb       (src_b),
            .cur_depth (cur_depth),
            .nxt_depth (nxt_depth),
            .drop_v    (lv[c]),
            .drop_d    (ld[c])
        );
    end

    // Pack the drop group, lowest latency class first
    always_comb begin
        int n;
        n          = 0;
        drop_valid = '0;
        drop_data  = '0;
        for (int c = 0; c < NCLS; c++) begin
            if (lv[c]) begin
                drop_valid[n]                 = 1'b1;
                drop_data[n*DATA_W +: DATA_W] = ld[c];
                n++;
            end
        end
        drop_count = 2'(n);
    end

    // R5
    property lanes_contiguous;
        @(posedge clk) disable iff (!rst_n) drop_valid[1] |-> drop_valid[0];
    endproperty
    lane_pack_chk: assert property (lanes_contiguous);

    // R4
    property fast_first;
        @(posedge clk) disable iff (!rst_n)
            (lv[CLS_FAST] && lv[CLS_SLOW]) |-> (drop_data[DATA_W-1:0] == ld[CLS_FAST] && drop_count == 2'd2);
    endproperty
    order_chk: assert property (fast_first);

    // R1
    property quiet_after_reset;
        @(posedge clk) $past(!rst_n) |-> (drop_valid == '0);
    endproperty
    reset_quiet_chk: assert property (quiet_after_reset);

endmodule

// File: tb/latency_drop_stager_tb.sv
`timescale 1ns/1ps
module latency_drop_stager_tb_top;

    localparam int W  = 8;
    localparam int N  = 32;
    localparam int LF = 1;
    localparam int LS = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           issue_valid = 1'b0, issue_op = 1'b0, call_req = 1'b0, ret_req = 1'b0;
    logic [W-1:0]   src_a = '0, src_b = '0;
    logic [1:0]     drop_valid;
    logic [2*W-1:0] drop_data;
    logic [1:0]     drop_count;

    always #2 clk = ~clk;

    latency_drop_stager #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .src_a(src_a), .src_b(src_b), .call_req(call_req), .ret_req(ret_req),
        .drop_valid(drop_valid), .drop_data(drop_data), .drop_count(drop_count)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic         p_iss [N], p_op [N], p_call [N], p_ret [N];
    logic [W-1:0] p_a [N], p_b [N];
    int           dep [N+1];
    logic         ev [N+1][2];
    logic [W-1:0] ed [N+1][2];

    task automatic clr_plan();
        for (int c = 0; c < N; c++) begin
            p_iss[c] = 0; p_op[c] = 0; p_call[c] = 0; p_ret[c] = 0; p_a[c] = '0; p_b[c] = '0;
        end
    endtask

    task automatic put(int t, bit op, logic [W-1:0] a, logic [W-1:0] b);
        p_iss[t] = 1; p_op[t] = op; p_a[t] = a; p_b[t] = b;
    endtask

    // Expected drops: count cycles owned by the issuing frame
    task automatic model();
        dep[0] = 0;
        for (int c = 0; c < N; c++) begin
            dep[c+1] = dep[c];
            if (p_call[c] && !p_ret[c] && dep[c] < 7) dep[c+1] = dep[c] + 1;
            if (p_ret[c] && !p_call[c] && dep[c] > 0) dep[c+1] = dep[c] - 1;
        end
        for (int c = 0; c <= N; c++) begin
            ev[c][0] = 0; ev[c][1] = 0; ed[c][0] = '0; ed[c][1] = '0;
        end
        for (int t = 0; t < N; t++) begin
            if (p_iss[t]) begin
                int d, need;
                logic [W-1:0] v;
                d    = dep[t];
                need = (p_op[t] ? LS : LF) - 1;
                v    = p_op[t] ? W'(p_a[t] * p_b[t]) : W'(p_a[t] + p_b[t]);
                for (int c = t + 1; c <= N; c++) begin
                    if (dep[c] < d) break;
                    if (dep[c] == d) begin
                        if (need == 0) begin
                            ev[c][p_op[t]] = 1; ed[c][p_op[t]] = v;
                            break;
                        end
                        need--;
                    end
                end
            end
        end
    endtask

    task automatic check_cycle(int c, string tag);
        logic [1:0]     xv;
        logic [2*W-1:0] xd;
        logic [1:0]     xc;
        int k;
        xv = '0; xd = '0; k = 0;
        for (int cl = 0; cl < 2; cl++) begin
            if (ev[c][cl]) begin
                xv[k] = 1'b1;
                xd[k*W +: W] = ed[c][cl];
                k++;
            end
        end
        xc = 2'(k);
        n_chk++;
        if (drop_valid !== xv || drop_data !== xd || drop_count !== xc) begin
            n_fail++;
            $display("FAIL %s cycle %0d: got v=%b d=%h n=%0d, expected v=%b d=%h n=%0d",
                     tag, c, drop_valid, drop_data, drop_count, xv, xd, xc);
        end
    endtask

    task automatic run(string tag);
        model();
        @(negedge clk); rst_n = 0;
        issue_valid = 0; call_req = 0; ret_req = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int c = 0; c <= N; c++) begin
            if (c > 0) @(negedge clk);
            check_cycle(c, tag);
            if (c < N) begin
                issue_valid = p_iss[c]; issue_op = p_op[c]; src_a = p_a[c]; src_b = p_b[c];
                call_req = p_call[c]; ret_req = p_ret[c];
            end else begin
                issue_valid = 0; call_req = 0; ret_req = 0;
            end
        end
    endtask

    initial begin
        // R1: reset with a result in flight, then silence
        @(negedge clk); rst_n = 1;
        issue_valid = 1; issue_op = 1; src_a = 8'd9; src_b = 8'd9;
        @(negedge clk); issue_valid = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int c = 0; c < 5; c++) begin
            n_chk++;
            if (drop_valid !== 2'b00 || drop_count !== 2'd0 || drop_data !== '0) begin
                n_fail++;
                $display("FAIL R1 cycle %0d: got v=%b d=%h n=%0d, expected v=00 d=0000 n=0",
                         c, drop_valid, drop_data, drop_count);
            end
            @(negedge clk);
        end

        // R2: back-to-back adds over a value sweep
        for (int s = 0; s < 3; s++) begin
            clr_plan();
            for (int c = 0; c < 16; c++) put(c, 0, W'(c * 37 + s * 91), W'(255 - c * 11 + s));
            run("R2");
        end

        // R3: back-to-back multiplies over a value sweep
        for (int s = 0; s < 3; s++) begin
            clr_plan();
            for (int c = 0; c < 16; c++) put(c, 1, W'(c * 19 + s * 5 + 3), W'(c + 7 * s + 2));
            run("R3");
        end

        // R4/R5: slow then fast at gaps 0..4, and an alternating mix
        for (int g = 0; g <= 4; g++) begin
            clr_plan();
            put(2, 1, W'(5 + g), 8'd7);
            put(2 + g, 0, W'(100 + g), 8'd60);
            run(g == 2 ? "R4" : "R5");
        end
        clr_plan();
        for (int c = 0; c < 20; c++) put(c, c[0], W'(c * 3 + 1), W'(c * 5 + 2));
        run("R4");

        // R6/R7: call offset against call length, with a fast op inside the callee
        for (int k = 0; k <= 3; k++) begin
            for (int len = 1; len <= 3; len++) begin
                clr_plan();
                put(2, 1, W'(11 + k), W'(13 + len));
                p_call[2 + k] = 1;
                p_ret[2 + k + len] = 1;
                put(3 + k, 0, W'(40 + k), W'(len));
                run(k == 0 ? "R7" : "R6");
            end
        end

        // R8: nested frames, each with results in flight
        clr_plan();
        put(1, 1, 8'd6, 8'd7);
        p_call[2] = 1;
        put(4, 1, 8'd8, 8'd9);
        p_call[5] = 1;
        put(7, 0, 8'd50, 8'd25);
        put(8, 1, 8'd3, 8'd4);
        p_ret[12] = 1;
        p_ret[17] = 1;
        run("R8");

        // R9: a frame dies with ops in flight, including one issued on the return
        clr_plan();
        p_call[1] = 1;
        put(3, 1, 8'd12, 8'd12);
        put(4, 0, 8'd1, 8'd2);
        p_ret[4] = 1;
        put(7, 0, 8'd70, 8'd7);
        run("R9");

        // R10: call+return together, return at depth 0
        clr_plan();
        put(2, 1, 8'd15, 8'd3);
        p_call[3] = 1; p_ret[3] = 1;
        p_ret[4] = 1;
        put(4, 0, 8'd33, 8'd44);
        put(6, 1, 8'd2, 8'd200);
        p_ret[6] = 1;
        run("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        done = 1;
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule